// File: doc/BRIEF.md
# Serial Result Port for a Successive-Approximation Converter

This block is the digital sequencer and serial output stage that sits between a successive-approximation converter core and a host serial bus. The host drives an active-low select line and a serial clock. Every step of a conversion is timed by the host's falling clock edges: tracking, the switch to hold, capturing the core's result word, and shifting that word out. The block has no clock of its own.

When select is released, the port returns at once to a powered-down state with its data line undriven. All of its registers clear asynchronously. After select falls, the host gives a fixed 24-edge frame. The frame holds a run of zero bits, then the 14 result bits with the most significant first, then two extra resolution bits. If the host keeps clocking after the frame ends, the port sends zeros until select rises again. Raising select part way through a frame abandons the conversion.

Top module: `sar_serial_port`

## Requirements
- R1: While `sel_n` is high, `sdo_oe_o`, `awake_o`, `hold_o`, `latch_o` and `sdo_o` are all 0, and every internal register is held cleared.
- R2: Once `sel_n` falls, `sdo_oe_o` and `awake_o` read 1 and `sdo_o` reads 0 before any falling clock edge has occurred.
- R3: `hold_o` is 0 before the 6th falling `sclk` edge after select falls, and it is 1 from that edge until select rises.
- R4: `sdo_o` changes only on falling `sclk` edges; it has the same value just before and just after each rising edge.
- R5: `sdo_o` stays 0 from the fall of select through the 7th falling edge, which gives eight leading zero bit slots.
- R6: The 16-bit `result_i` is captured on the 7th falling edge. `latch_o` is 1 only between the 7th and 8th falling edges. Changes to `result_i` after the capture do not alter the frame.
- R7: After falling edge 8+i (i = 0..15), `sdo_o` equals `result_i[15-i]` as captured. Bits 15..2 carry data bits 13..0 and bits 1..0 carry the two sub-bits.
- R8: After the 24th falling edge and on every later edge while select stays low, `sdo_o` is 0 and `hold_o` remains 1.
- R9: Raising `sel_n` mid-frame aborts the conversion at once (R1 state). The next select fall starts a fresh frame from the first leading zero with a newly captured result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_n | input | 1 | Active-low select; high forces shutdown and clears all state |
| sclk | input | 1 | Host serial clock; falling edges advance the frame |
| result_i | input | 16 | Converter core word: 14 data bits then 2 sub-bits, MSB in bit 15 |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the data pad (0 = high impedance) |
| awake_o | output | 1 | Power-state flag, 1 while powered up |
| hold_o | output | 1 | Track/hold control, 1 = hold (conversion running) |
| latch_o | output | 1 | Strobe marking the edge interval after the result was captured |

## Verification
The bench uses the default parameters: 14 data bits, 2 sub-bits, 8 leading zero slots and a 6-edge acquisition. This makes a 24-edge frame whose capture edge falls one edge before the MSB. With these values the bench can reach every phase boundary of a real frame: the hold switch at edge 6, the capture at edge 7, the MSB at edge 8, the last sub-bit at edge 23, and the point where the 5-bit edge counter saturates. Frames are run with full-length and extended clocking, with a result input that changes after capture, and with an abort at edge 12 followed by a clean frame.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

    // Frame phase as seen between two falling serial clock edges
    typedef enum logic [2:0] {
        PH_TRACK   = 3'd0,
        PH_HOLD    = 3'd1,
        PH_LATCHED = 3'd2,
        PH_SHIFT   = 3'd3,
        PH_TAIL    = 3'd4
    } frame_phase_e;

endpackage

// File: rtl/sar_edge_counter.sv
module sar_edge_counter
    import sar_port_pkg::*;
#(
    parameter int FRAME_EDGES = 24,
    parameter int ACQ_EDGES   = 6,
    parameter int LOAD_EDGE   = 7,
    parameter int CNT_W       = 5
) (
    input  logic             sel_n,
    input  logic             sclk,
    output logic [CNT_W-1:0] cnt_o,
    output frame_phase_e     phase_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != CNT_W'(FRAME_EDGES)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(negedge sclk or posedge sel_n) begin
        if (sel_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.cnt < CNT_W'(ACQ_EDGES)) begin
            phase_o = PH_TRACK;
        end else if (st_q.cnt < CNT_W'(LOAD_EDGE)) begin
            phase_o = PH_HOLD;
        end else if (st_q.cnt == CNT_W'(LOAD_EDGE)) begin
            phase_o = PH_LATCHED;
        end else if (st_q.cnt < CNT_W'(FRAME_EDGES)) begin
            phase_o = PH_SHIFT;
        end else begin
            phase_o = PH_TAIL;
        end
    end

    assign cnt_o = st_q.cnt;

    // R8
    cnt_saturate_chk: assert property (@(negedge sclk) disable iff (sel_n)
        (st_q.cnt == CNT_W'(FRAME_EDGES)) |=> (st_q.cnt == CNT_W'(FRAME_EDGES)));

    // R8
    cnt_bound_chk: assert property (@(negedge sclk) disable iff (sel_n)
        st_q.cnt <= CNT_W'(FRAME_EDGES));

endmodule

// File: rtl/sar_result_shifter.sv
module sar_result_shifter #(
    parameter int RES_W       = 16,
    parameter int FRAME_EDGES = 24,
    parameter int LOAD_EDGE   = 7,
    parameter int CNT_W       = 5
) (
    input  logic             sel_n,
    input  logic             sclk,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [RES_W-1:0] result_i,
    output logic             sdo_o
);

    typedef struct packed {
        logic [RES_W-1:0] shreg;
        logic             sdo;
    } shift_state_t;

    shift_state_t st_d, st_q;

    logic load_now, shift_now;

    assign load_now  = (cnt_i == CNT_W'(LOAD_EDGE - 1));
    assign shift_now = (cnt_i >= CNT_W'(LOAD_EDGE)) && (cnt_i < CNT_W'(FRAME_EDGES));

    always_comb begin
        st_d     = st_q;
        st_d.sdo = 1'b0;
        if (load_now) begin
            st_d.shreg = result_i;
        end else if (shift_now) begin
            st_d.sdo   = st_q.shreg[RES_W-1];
            st_d.shreg = {st_q.shreg[RES_W-2:0], 1'b0};
        end
    end

    always_ff @(negedge sclk or posedge sel_n) begin
        if (sel_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_o = st_q.sdo;

    // R7
    shift_order_chk: assert property (@(negedge sclk) disable iff (sel_n)
        shift_now |=> (st_q.sdo == $past(st_q.shreg[RES_W-1])));

    // R5
    lead_zero_chk: assert property (@(negedge sclk) disable iff (sel_n)
        (cnt_i <= CNT_W'(LOAD_EDGE)) |-> !st_q.sdo);

    // R8
    tail_zero_chk: assert property (@(negedge sclk) disable iff (sel_n)
        (cnt_i == CNT_W'(FRAME_EDGES)) |-> !st_q.sdo);

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_port_pkg::*;
#(
    parameter int DATA_W     = 14,
    parameter int SUB_W      = 2,
    parameter int LEAD_ZEROS = 8,
    parameter int ACQ_EDGES  = 6
) (
    input  logic                      sel_n,
    input  logic                      sclk,
    input  logic [DATA_W+SUB_W-1:0]   result_i,
    output logic                      sdo_o,
    output logic                      sdo_oe_o,
    output logic                      awake_o,
    output logic                      hold_o,
    output logic                      latch_o
);

    localparam int RES_W       = DATA_W + SUB_W;
    localparam int FRAME_EDGES = LEAD_ZEROS + RES_W;
    localparam int LOAD_EDGE   = LEAD_ZEROS - 1;
    localparam int CNT_W       = $clog2(FRAME_EDGES + 1);

    logic [CNT_W-1:0] cnt;
    frame_phase_e     phase;
    logic             sdo_raw;

    sar_edge_counter #(
        .FRAME_EDGES (FRAME_EDGES),
        .ACQ_EDGES   (ACQ_EDGES),
        .LOAD_EDGE   (LOAD_EDGE),
        .CNT_W       (CNT_W)
    ) u_counter (
        .sel_n   (sel_n),
        .sclk    (sclk),
        .cnt_o   (cnt),
        .phase_o (phase)
    );

    sar_result_shifter #(
        .RES_W       (RES_W),
        .FRAME_EDGES (FRAME_EDGES),
        .LOAD_EDGE   (LOAD_EDGE),
        .CNT_W       (CNT_W)
    ) u_shifter (
        .sel_n    (sel_n),
        .sclk     (sclk),
        .cnt_i    (cnt),
        .result_i (result_i),
        .sdo_o    (sdo_raw)
    );

    assign awake_o  = !sel_n;
    assign sdo_oe_o = !sel_n;
    assign sdo_o    = sdo_raw;
    assign hold_o   = (phase != PH_TRACK);
    assign latch_o  = (phase == PH_LATCHED);

    // R6
    latch_pulse_chk: assert property (@(negedge sclk) disable iff (sel_n)
        latch_o |=> !latch_o);

    // R3
    hold_keep_chk: assert property (@(negedge sclk) disable iff (sel_n)
        hold_o |=> hold_o);

    // R3
    hold_late_chk: assert property (@(negedge sclk) disable iff (sel_n)
        latch_o |-> hold_o);

endmodule

// File: tb/tb_sar_serial_port.sv
module tb_sar_serial_port;

    logic        sel_n;
    logic        sclk;
    logic [15:0] result_i;
    logic        sdo_o, sdo_oe_o, awake_o, hold_o, latch_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // expected: {oe, awake, hold, latch, sdo}
    logic [4:0] exp_q[$];
    string      tag_q[$];

    sar_serial_port dut (
        .sel_n    (sel_n),
        .sclk     (sclk),
        .result_i (result_i),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .awake_o  (awake_o),
        .hold_o   (hold_o),
        .latch_o  (latch_o)
    );

    initial sclk = 1'b0;
    always #4 sclk = ~sclk;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic push_off(input string tag);
        exp_q.push_back(5'b00000);
        tag_q.push_back(tag);
    endtask

    // Run one frame of nedges falling edges, then raise select.
    task automatic run_frame(input logic [15:0] res, input int nedges,
                             input logic swap_after, input string end_tag);
        @(negedge sclk);
        #1;
        sel_n    = 1'b0;
        result_i = res;
        for (int k = 0; k <= nedges; k++) begin
            logic [4:0] e;
            e[4] = 1'b1;
            e[3] = 1'b1;
            e[2] = (k >= 6);
            e[1] = (k == 7);
            e[0] = (k >= 8 && k <= 23) ? res[15-(k-8)] : 1'b0;
            exp_q.push_back(e);
            if (k == 0)
                tag_q.push_back("R2");
            else if (k < 8)
                tag_q.push_back("R5");
            else if (k <= 23)
                tag_q.push_back(swap_after ? "R6" : "R7");
            else
                tag_q.push_back("R8");
        end
        push_off(end_tag);
        for (int k = 1; k <= nedges; k++) begin
            @(negedge sclk);
            #1;
            if (swap_after && k == 8) result_i = ~res;
        end
        @(posedge sclk);
        #3;
        sel_n = 1'b1;
        while (exp_q.size() != 0) begin
            @(posedge sclk);
            #3;
        end
    endtask

    // Monitor: pops one expectation per rising edge
    initial begin
        forever begin
            logic       pre;
            logic [4:0] e;
            string      t;
            @(negedge sclk);
            #3;
            pre = sdo_o;
            @(posedge sclk);
            #2;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(sdo_oe_o == e[4], (e[4] ? t : t), "sdo_oe", sdo_oe_o, e[4]);
                check(awake_o == e[3], t, "awake", awake_o, e[3]);
                check(hold_o == e[2], (e[4] ? "R3" : t), "hold", hold_o, e[2]);
                check(latch_o == e[1], (e[4] ? "R6" : t), "latch", latch_o, e[1]);
                check(sdo_o == e[0], t, "sdo", sdo_o, e[0]);
                check(pre == sdo_o, "R4", "sdo across rising edge", sdo_o, pre);
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge sclk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 200000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        sel_n    = 1'b1;
        result_i = 16'h0000;
        // R1: shutdown state before any frame
        push_off("R1");
        push_off("R1");
        while (exp_q.size() != 0) begin
            @(posedge sclk);
            #3;
        end
        // R7: full frames with distinct patterns
        run_frame(16'hA5C3, 24, 1'b0, "R1");
        run_frame(16'hFFFF, 24, 1'b0, "R1");
        run_frame(16'h8001, 24, 1'b0, "R1");
        // R8: extended clocking gives trailing zeros
        run_frame(16'h7FFE, 31, 1'b0, "R8");
        // R6: result input changes after capture
        run_frame(16'h3C96, 24, 1'b1, "R1");
        // R9: abort mid-conversion, then a clean frame
        run_frame(16'hFFFF, 12, 1'b0, "R9");
        run_frame(16'h1234, 25, 1'b0, "R9");
        // R9: abort right after capture
        run_frame(16'hBEEF, 7, 1'b0, "R9");
        run_frame(16'h0F0F, 24, 1'b0, "R1");
        repeat (3) @(posedge sclk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule